// File: doc/BRIEF.md
# Command Packet Decoder

This block sits behind a command fetcher and turns a stream of 32-bit command words into actions. The first word of every packet is a header, whose top two bits select one of four packet kinds: a burst of writes to consecutive registers, a pair of writes to two independent registers, a one-word no-op, or an opcode packet. Register writes land in a local register file that can be read back combinationally. Four opcodes are turned into decoded commands: launch of an indirect buffer, an auto-indexed draw, a memory write signalled by an event, and a state-invalidate mask. Any other opcode has its payload consumed and discarded.

Words arrive on a valid/ready handshake. The decoder accepts one word per cycle, consumes exactly the number of words that the header announces, and reports each packet's word count when it finishes so that the fetcher can cross-check its own length accounting. All command outputs are single-cycle pulses, registered, and appear in the cycle after the word that completes them is accepted.

Top module: `cmd_pkt_decoder`

## Requirements
- R1: A header word equal to 32'h0 is consumed as a one-word packet: no register write and no command pulse, and the completion report gives 1 word.
- R2: A header with bits [31:30] = 0 announces (bits [29:16] + 1) payload words; payload word k is written to register index (bits [15:0] + k).
- R3: A header with bits [31:30] = 1 is followed by exactly two words; the first is written to the register index in header bits [10:0], the second to the index in bits [21:11].
- R4: A header with bits [31:30] = 2 is a one-word no-op with no write and no command.
- R5: A header with bits [31:30] = 3 announces (bits [29:16] + 1) payload words and carries its opcode in bits [14:8]; an opcode other than 7'h3F, 7'h22, 7'h58 and 7'h3B produces no command and its full payload is skipped, so the next word is treated as a header.
- R6: A register write whose index is not below REG_COUNT leaves the register file unchanged and raises no write pulse, while writes in the same burst that are in range still happen.
- R7: Opcode 7'h22 decodes its second payload word: index count from bits [31:16], primitive type from bits [5:0]; a draw pulse is raised only when the source select in bits [7:6] equals 2.
- R8: Opcode 7'h3F raises an indirect-buffer request whose address is the first payload word and whose length in dwords is the second.
- R9: Opcode 7'h58 raises a memory write carrying the third payload word as data and the second payload word, with bits [1:0] cleared, as address.
- R10: Opcode 7'h3B raises an invalidate pulse carrying the first payload word as mask.
- R11: In the cycle after the last word of a packet is accepted, a completion pulse reports the number of words consumed, 1 plus the payload count.
- R12: The ready output is high from the first cycle after reset; cycles with valid low between words of a packet neither lose nor add words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command word valid |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Decoder accepts a word |
| rd_idx | input | 16 | Register file read index |
| rd_data | output | 32 | Register file read data (0 when out of range) |
| reg_we | output | 1 | Register write performed |
| reg_idx | output | 16 | Index of the write performed |
| reg_wdata | output | 32 | Data of the write performed |
| draw_valid | output | 1 | Draw command pulse |
| draw_count | output | 16 | Draw index count |
| draw_prim | output | 6 | Draw primitive type |
| mem_we | output | 1 | Event memory write pulse |
| mem_addr | output | 32 | Memory write address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| ib_valid | output | 1 | Indirect-buffer request pulse |
| ib_addr | output | 32 | Indirect-buffer address |
| ib_len | output | 32 | Indirect-buffer length in dwords |
| inv_valid | output | 1 | State-invalidate pulse |
| inv_mask | output | 32 | Invalidation mask |
| pkt_done | output | 1 | Packet completed |
| pkt_words | output | 15 | Words consumed by the completed packet |

## Verification
The checker assumes that the word stream is well framed: every header is followed by at least as many words as it announces before the next header, and a draw opcode carries the draw word in its second payload slot. It also relies on in_data staying steady while in_valid is low so that its source-select property, which looks at the previous input, refers to the accepted word. The directed bench always sends complete packets, holds in_data between words, and inserts idle gaps only between complete words so that framing never slips.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

   typedef enum logic [1:0] {
      KIND_REG_BURST = 2'd0,
      KIND_REG_PAIR  = 2'd1,
      KIND_NOP       = 2'd2,
      KIND_OPCODE    = 2'd3
   } pkt_kind_e;

   localparam logic [6:0] OPC_INDIRECT   = 7'h3F;
   localparam logic [6:0] OPC_DRAW       = 7'h22;
   localparam logic [6:0] OPC_EVENT_MEM  = 7'h58;
   localparam logic [6:0] OPC_INVALIDATE = 7'h3B;

   localparam int LEN_W = 15;

   typedef struct packed {
      pkt_kind_e        kind;
      logic [LEN_W-1:0] len;
      logic [15:0]      base;
      logic [10:0]      pair_first;
      logic [10:0]      pair_second;
      logic [6:0]       opc;
   } hdr_t;

endpackage

// File: rtl/cpd_hdr_split.sv
module cpd_hdr_split
   import cpd_pkg::*;
(
   input  logic [31:0] word,
   output hdr_t        hdr
);
   logic [LEN_W-1:0] field_len;

   always_comb begin
      field_len = {1'b0, word[29:16]} + LEN_W'(1);
      hdr.kind        = pkt_kind_e'(word[31:30]);
      hdr.base        = word[15:0];
      hdr.pair_first  = word[10:0];
      hdr.pair_second = word[21:11];
      hdr.opc         = word[14:8];
      unique case (word[31:30])
         2'd0, 2'd3: hdr.len = field_len;
         2'd1:       hdr.len = LEN_W'(2);
         default:    hdr.len = '0;
      endcase
      if (word == 32'h0) hdr.len = '0;
   end
endmodule

// File: rtl/cpd_regfile.sv
module cpd_regfile #(
   parameter int REG_COUNT = 64,
   parameter int DW        = 32,
   parameter int IW        = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_req,
   input  logic [IW:0]   wr_idx,
   input  logic [DW-1:0] wr_data,
   output logic          wr_taken,
   input  logic [IW-1:0] rd_idx,
   output logic [DW-1:0] rd_data
);
   if (REG_COUNT < 1 || REG_COUNT > (1 << IW)) begin : g_bad_count
      $error("cpd_regfile: REG_COUNT out of range");
   end

   logic [DW-1:0] rows [REG_COUNT];

   assign wr_taken = wr_req && (wr_idx < (IW+1)'(REG_COUNT));

   for (genvar r = 0; r < REG_COUNT; r++) begin : g_row
      always_ff @(posedge clk) begin
         if (!rst_n)
            rows[r] <= '0;
         else if (wr_taken && wr_idx == (IW+1)'(r))
            rows[r] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int r = 0; r < REG_COUNT; r++)
         if (rd_idx == IW'(r)) rd_data = rows[r];
   end
endmodule

// File: rtl/cmd_pkt_decoder.sv
module cmd_pkt_decoder
   import cpd_pkg::*;
#(
   parameter int REG_COUNT = 64
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic [31:0] in_data,
   output logic        in_ready,
   input  logic [15:0] rd_idx,
   output logic [31:0] rd_data,
   output logic        reg_we,
   output logic [15:0] reg_idx,
   output logic [31:0] reg_wdata,
   output logic        draw_valid,
   output logic [15:0] draw_count,
   output logic [5:0]  draw_prim,
   output logic        mem_we,
   output logic [31:0] mem_addr,
   output logic [31:0] mem_wdata,
   output logic        ib_valid,
   output logic [31:0] ib_addr,
   output logic [31:0] ib_len,
   output logic        inv_valid,
   output logic [31:0] inv_mask,
   output logic        pkt_done,
   output logic [14:0] pkt_words
);
   localparam int IW = 16;

   hdr_t             hdr_now, hdr_q;
   logic             busy_q, ready_q;
   logic [LEN_W-1:0] pos_q;
   logic [31:0]      held_addr_q;
   logic             accept, last_word, wr_req, wr_taken;
   logic [IW:0]      wr_idx;

   cpd_hdr_split u_split (.word(in_data), .hdr(hdr_now));

   assign in_ready  = ready_q;
   assign accept    = in_valid && ready_q;
   assign last_word = busy_q && (pos_q == hdr_q.len - LEN_W'(1));

   always_comb begin
      wr_req = 1'b0;
      wr_idx = '0;
      if (accept && busy_q) begin
         unique case (hdr_q.kind)
            KIND_REG_BURST: begin
               wr_req = 1'b1;
               wr_idx = {1'b0, hdr_q.base} + (IW+1)'(pos_q);
            end
            KIND_REG_PAIR: begin
               wr_req = 1'b1;
               wr_idx = (pos_q == '0) ? (IW+1)'(hdr_q.pair_first)
                                      : (IW+1)'(hdr_q.pair_second);
            end
            default: ;
         endcase
      end
   end

   cpd_regfile #(.REG_COUNT(REG_COUNT), .DW(32), .IW(IW)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .wr_req(wr_req), .wr_idx(wr_idx), .wr_data(in_data),
      .wr_taken(wr_taken), .rd_idx(rd_idx), .rd_data(rd_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready_q <= 1'b0; busy_q <= 1'b0; hdr_q <= '0; pos_q <= '0;
         held_addr_q <= '0;
         reg_we <= 1'b0; reg_idx <= '0; reg_wdata <= '0;
         draw_valid <= 1'b0; draw_count <= '0; draw_prim <= '0;
         mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
         ib_valid <= 1'b0; ib_addr <= '0; ib_len <= '0;
         inv_valid <= 1'b0; inv_mask <= '0;
         pkt_done <= 1'b0; pkt_words <= '0;
      end else begin
         ready_q    <= 1'b1;
         reg_we     <= wr_taken;
         draw_valid <= 1'b0;
         mem_we     <= 1'b0;
         ib_valid   <= 1'b0;
         inv_valid  <= 1'b0;
         pkt_done   <= 1'b0;
         if (wr_taken) begin
            reg_idx   <= wr_idx[IW-1:0];
            reg_wdata <= in_data;
         end
         if (accept && !busy_q) begin
            if (hdr_now.len == '0) begin
               pkt_done  <= 1'b1;
               pkt_words <= 15'd1;
            end else begin
               busy_q <= 1'b1;
               hdr_q  <= hdr_now;
               pos_q  <= '0;
            end
         end else if (accept) begin
            pos_q <= pos_q + LEN_W'(1);
            if (hdr_q.kind == KIND_OPCODE) begin
               unique case (hdr_q.opc)
                  OPC_INDIRECT: begin
                     if (pos_q == LEN_W'(0)) held_addr_q <= in_data;
                     if (pos_q == LEN_W'(1)) begin
                        ib_valid <= 1'b1;
                        ib_addr  <= held_addr_q;
                        ib_len   <= in_data;
                     end
                  end
                  OPC_DRAW: begin
                     if (pos_q == LEN_W'(1) && in_data[7:6] == 2'd2) begin
                        draw_valid <= 1'b1;
                        draw_count <= in_data[31:16];
                        draw_prim  <= in_data[5:0];
                     end
                  end
                  OPC_EVENT_MEM: begin
                     if (pos_q == LEN_W'(1)) held_addr_q <= {in_data[31:2], 2'b00};
                     if (pos_q == LEN_W'(2)) begin
                        mem_we    <= 1'b1;
                        mem_addr  <= held_addr_q;
                        mem_wdata <= in_data;
                     end
                  end
                  OPC_INVALIDATE: begin
                     if (pos_q == LEN_W'(0)) begin
                        inv_valid <= 1'b1;
                        inv_mask  <= in_data;
                     end
                  end
                  default: ;
               endcase
            end
            if (last_word) begin
               busy_q    <= 1'b0;
               pkt_done  <= 1'b1;
               pkt_words <= hdr_q.len + LEN_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/cpd_checker.sv
module cpd_checker #(
   parameter int REG_COUNT = 64
) (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [31:0] in_data,
   input logic        in_ready,
   input logic        reg_we,
   input logic [15:0] reg_idx,
   input logic        draw_valid,
   input logic        mem_we,
   input logic [31:0] mem_addr,
   input logic        ib_valid,
   input logic        inv_valid,
   input logic        pkt_done,
   input logic [14:0] pkt_words
);
   assert_reg_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> (32'(reg_idx) < REG_COUNT));

   assert_words_nonzero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_done |-> (pkt_words != 15'd0));

   assert_done_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_done |-> $past(in_valid && in_ready));

   assert_mem_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr[1:0] == 2'b00));

   assert_draw_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
      draw_valid |-> ($past(in_data[7:6]) == 2'd2));

   assert_single_command_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ib_valid, draw_valid, mem_we, inv_valid}));

   assert_ready_after_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> in_ready);
endmodule

bind cmd_pkt_decoder cpd_checker #(.REG_COUNT(REG_COUNT)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
   .in_ready(in_ready), .reg_we(reg_we), .reg_idx(reg_idx),
   .draw_valid(draw_valid), .mem_we(mem_we), .mem_addr(mem_addr),
   .ib_valid(ib_valid), .inv_valid(inv_valid), .pkt_done(pkt_done),
   .pkt_words(pkt_words)
);

// File: tb/cmd_pkt_decoder_tb.sv
module cmd_pkt_decoder_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        in_ready;
   logic [15:0] rd_idx = '0;
   logic [31:0] rd_data;
   logic        reg_we;
   logic [15:0] reg_idx;
   logic [31:0] reg_wdata;
   logic        draw_valid;
   logic [15:0] draw_count;
   logic [5:0]  draw_prim;
   logic        mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        ib_valid;
   logic [31:0] ib_addr, ib_len;
   logic        inv_valid;
   logic [31:0] inv_mask;
   logic        pkt_done;
   logic [14:0] pkt_words;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   cmd_pkt_decoder #(.REG_COUNT(64)) u_dut (.*);

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
      chk(act === exp, req, act, exp);
   endtask

   task automatic send(input logic [31:0] w);
      in_valid = 1'b1;
      in_data  = w;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   function automatic logic [3:0] cmd_bits();
      return {ib_valid, draw_valid, mem_we, inv_valid};
   endfunction

   task automatic read_reg(input logic [15:0] i, input logic [31:0] exp, input string req);
      rd_idx = i;
      #1;
      eq(req, rd_data, exp);
   endtask

   task automatic t_reset();
      eq("R12 ready", 32'(in_ready), 1);
      eq("R11 no done", 32'(pkt_done), 0);
      read_reg(16'd5, 32'h0, "R2 reset reg");
   endtask

   task automatic t_zero();
      send(32'h0);
      eq("R1 done", 32'(pkt_done), 1);
      eq("R1 words", 32'(pkt_words), 1);
      eq("R1 no write", 32'(reg_we), 0);
   endtask

   task automatic t_burst();
      send(32'h0002_0005);
      for (int k = 0; k < 3; k++) begin
         send(32'hA000_0000 + 32'(k));
         eq("R2 we", 32'(reg_we), 1);
         eq("R2 idx", 32'(reg_idx), 32'(5 + k));
         if (k == 2) begin
            eq("R11 done", 32'(pkt_done), 1);
            eq("R11 words", 32'(pkt_words), 4);
         end else eq("R11 not done", 32'(pkt_done), 0);
      end
      read_reg(16'd5, 32'hA000_0000, "R2 reg5");
      read_reg(16'd7, 32'hA000_0002, "R2 reg7");
   endtask

   task automatic t_range();
      send(32'h0002_003E);
      send(32'h1111_1111);
      eq("R6 62 we", 32'(reg_we), 1);
      send(32'h2222_2222);
      eq("R6 63 we", 32'(reg_we), 1);
      send(32'h3333_3333);
      eq("R6 64 dropped", 32'(reg_we), 0);
      eq("R6 words", 32'(pkt_words), 4);
      read_reg(16'd63, 32'h2222_2222, "R6 reg63");
      read_reg(16'd64, 32'h0, "R6 reg64");
   endtask

   task automatic t_pair();
      send(32'h4000_A00A);
      send(32'hCAFE_0001);
      eq("R3 first idx", 32'(reg_idx), 10);
      send(32'hCAFE_0002);
      eq("R3 second idx", 32'(reg_idx), 20);
      eq("R3 words", 32'(pkt_words), 3);
      read_reg(16'd10, 32'hCAFE_0001, "R3 reg10");
      read_reg(16'd20, 32'hCAFE_0002, "R3 reg20");
   endtask

   task automatic t_nop();
      send(32'h8000_0000);
      eq("R4 words", 32'(pkt_words), 1);
      eq("R4 no write", 32'(reg_we), 0);
      eq("R4 no cmd", 32'(cmd_bits()), 0);
   endtask

   task automatic t_indirect();
      send(32'hC001_3F00);
      send(32'h0040_0000);
      eq("R8 early", 32'(ib_valid), 0);
      send(32'h0000_0080);
      eq("R8 valid", 32'(ib_valid), 1);
      eq("R8 addr", ib_addr, 32'h0040_0000);
      eq("R8 len", ib_len, 32'h80);
   endtask

   task automatic t_draw();
      send(32'hC001_2200);
      send(32'h0000_0000);
      send(32'h0064_0084);
      eq("R7 valid", 32'(draw_valid), 1);
      eq("R7 count", 32'(draw_count), 100);
      eq("R7 prim", 32'(draw_prim), 4);
      send(32'hC001_2200);
      send(32'h0000_0000);
      send(32'h0064_0044);
      eq("R7 bad src", 32'(draw_valid), 0);
   endtask

   task automatic t_event();
      send(32'hC002_5800);
      send(32'h3);
      send(32'h0000_1003);
      eq("R9 early", 32'(mem_we), 0);
      send(32'hDEAD_BEEF);
      eq("R9 we", 32'(mem_we), 1);
      eq("R9 addr", mem_addr, 32'h0000_1000);
      eq("R9 data", mem_wdata, 32'hDEAD_BEEF);
   endtask

   task automatic t_inv();
      send(32'hC000_3B00);
      send(32'h0000_00F5);
      eq("R10 valid", 32'(inv_valid), 1);
      eq("R10 mask", inv_mask, 32'hF5);
      eq("R10 words", 32'(pkt_words), 2);
   endtask

   task automatic t_unknown();
      send(32'hC003_1000);
      for (int k = 0; k < 4; k++) begin
         send(32'h0000_0009);
         eq("R5 no write", 32'(reg_we), 0);
         eq("R5 no cmd", 32'(cmd_bits()), 0);
      end
      eq("R5 words", 32'(pkt_words), 5);
      read_reg(16'd9, 32'h0, "R5 reg9 untouched");
      send(32'h8000_0000);
      eq("R5 next header", 32'(pkt_words), 1);
   endtask

   task automatic t_gaps();
      send(32'h0001_0030);
      repeat (3) @(negedge clk);
      send(32'h5555_0000);
      eq("R12 first idx", 32'(reg_idx), 48);
      repeat (2) @(negedge clk);
      eq("R12 not done", 32'(pkt_done), 0);
      send(32'h5555_0001);
      eq("R12 done", 32'(pkt_done), 1);
      eq("R12 words", 32'(pkt_words), 3);
      read_reg(16'd49, 32'h5555_0001, "R12 reg49");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_zero();
      t_burst();
      t_range();
      t_pair();
      t_nop();
      t_indirect();
      t_draw();
      t_event();
      t_inv();
      t_unknown();
      t_gaps();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%h expected=%h", 32'(0), 32'(1));
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule